// File: doc/BRIEF.md
# External Interrupt Pin Controller

This block watches one active-low external interrupt pin on behalf of a small CPU. The pin is brought into the clock domain through a synchronizer. A falling edge, or optionally a low level, sets a pending flag. The flag is forwarded to the CPU's interrupt priority logic as a request unless a mask bit blocks it. Masking never stops the flag from being set.

Software controls the block through a single 8-bit status/control register on a simple write/read peripheral port. The CPU also supplies a one-cycle vector-fetch acknowledge. In edge-only mode any acknowledge clears the flag. In level mode the flag stays set until an acknowledge has been seen and the pin has gone high again, and these two events may come in either order.

Top module: `ext_irq_ctrl`

## Requirements
- R1: After reset, `reg_rdata` reads 0x00 (flag, mask and level-mode bit all clear) and `irq_req` is 0. This holds even while the pin is held low.
- R2: When the pin changes from high to low, the flag (bit 3 of `reg_rdata`) is set on the third rising clock edge after the change. A synchronized sample of 1 followed by a sample of 0 counts as the falling edge.
- R3: In edge-only mode (bit 0 clear), the flag is cleared by a `vec_ack` pulse or by writing 1 to bit 2. While the pin stays low, it is not set again.
- R4: In level mode (bit 0 set), a synchronized low pin sets the flag even if no falling edge occurred.
- R5: In level mode, the flag clears only when an acknowledge has occurred and the synchronized pin is high, with the acknowledge coming either before or after the pin rises. It stays set while the pin is low.
- R6: Bit 1 set forces `irq_req` to 0 while the flag keeps latching. Once bit 1 is cleared, `irq_req` equals the flag.
- R7: Bits 7..4 and bit 2 always read 0. Bit 3 is read-only. A write loads bit 1 and bit 0 from `reg_wdata`.
- R8: A falling edge detected in the same cycle as an acknowledge leaves the flag set.
- R9: A write with bit 2 at 0 does not clear the flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin_n | input | 1 | Asynchronous active-low interrupt pin |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data |
| vec_ack | input | 1 | Vector-fetch acknowledge pulse from the CPU |
| irq_req | output | 1 | Masked interrupt request |

## Verification
The assertions assume three things about the inputs. `reg_wr`, `reg_wdata` and `vec_ack` are synchronous to `clk` and have known values once reset is released. Reset is applied at start-up. Only `irq_pin_n` may change at arbitrary times. The stimulus meets these assumptions by changing every input at the falling clock edge. It also holds the pin at each level for random stretches of several cycles, so that edges, levels and acknowledges overlap in every order.

// File: rtl/ext_irq_pkg.sv
package ext_irq_pkg;
   localparam int REG_W    = 8;
   localparam int BIT_MODE = 0;
   localparam int BIT_MASK = 1;
   localparam int BIT_ACK  = 2;
   localparam int BIT_FLAG = 3;

   typedef struct packed {
      logic mask;
      logic level_en;
   } irq_ctrl_t;
endpackage

// File: rtl/ext_irq_sync.sv
module ext_irq_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_n,
   output logic fall,
   output logic low
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("ext_irq_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[gi] <= 1'b1;
               else        chain_q[gi] <= pin_n;
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n)
               if (!rst_n) chain_q[gi] <= 1'b1;
               else        chain_q[gi] <= chain_q[gi-1];
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) prev_q <= 1'b1;
      else        prev_q <= chain_q[STAGES-1];

   assign fall = prev_q & ~chain_q[STAGES-1];
   assign low  = ~chain_q[STAGES-1];
endmodule

// File: rtl/ext_irq_pend.sv
module ext_irq_pend (
   input  logic clk,
   input  logic rst_n,
   input  logic fall,
   input  logic low,
   input  logic level_en,
   input  logic ack,
   output logic pend
);
   logic pend_q, acked_q;
   logic set_req;

   assign set_req = fall | (level_en & low & ~pend_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= 1'b0;
         acked_q <= 1'b0;
      end else if (set_req) begin
         pend_q  <= 1'b1;
         acked_q <= 1'b0;
      end else if (pend_q) begin
         if (level_en) begin
            if ((acked_q | ack) & ~low) begin
               pend_q  <= 1'b0;
               acked_q <= 1'b0;
            end else if (ack) begin
               acked_q <= 1'b1;
            end
         end else if (ack) begin
            pend_q  <= 1'b0;
            acked_q <= 1'b0;
         end
      end
   end

   assign pend = pend_q;

   // R2 and R8: a detected edge always leaves the flag set
   a_r8_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
      fall |=> pend_q);
   // R3: edge-only acknowledge clears
   a_r3_ack_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && !level_en && ack && !fall) |=> !pend_q);
   // R5: level mode holds while the pin is low
   a_r5_hold_low: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_q && level_en && low) |=> pend_q);
endmodule

// File: rtl/ext_irq_regs.sv
module ext_irq_regs
   import ext_irq_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [REG_W-1:0] wdata,
   input  logic             pend,
   output irq_ctrl_t        ctrl,
   output logic             soft_clr,
   output logic [REG_W-1:0] rdata
);
   irq_ctrl_t ctrl_q;
   logic      unused_wbits;

   always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) ctrl_q <= '0;
      else if (wr) begin
         ctrl_q.mask     <= wdata[BIT_MASK];
         ctrl_q.level_en <= wdata[BIT_MODE];
      end

   assign unused_wbits = ^{wdata[REG_W-1:BIT_FLAG]};
   assign soft_clr     = wr & wdata[BIT_ACK];
   assign ctrl         = ctrl_q;

   always_comb begin
      rdata           = '0;
      rdata[BIT_FLAG] = pend;
      rdata[BIT_MASK] = ctrl_q.mask;
      rdata[BIT_MODE] = ctrl_q.level_en;
   end

   // R7: a write loads the control bits
   a_r7_write_loads: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> (ctrl_q.level_en == $past(wdata[BIT_MODE])) &&
             (ctrl_q.mask == $past(wdata[BIT_MASK])));
endmodule

// File: rtl/ext_irq_ctrl.sv
module ext_irq_ctrl
   import ext_irq_pkg::*;
#(
   parameter int SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             irq_pin_n,
   input  logic             reg_wr,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   input  logic             vec_ack,
   output logic             irq_req
);
   logic      fall, low, pend, soft_clr;
   irq_ctrl_t ctrl;

   ext_irq_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .pin_n(irq_pin_n), .fall(fall), .low(low));

   ext_irq_regs u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .wdata(reg_wdata), .pend(pend),
      .ctrl(ctrl), .soft_clr(soft_clr), .rdata(reg_rdata));

   ext_irq_pend u_pend (
      .clk(clk), .rst_n(rst_n), .fall(fall), .low(low),
      .level_en(ctrl.level_en), .ack(vec_ack | soft_clr), .pend(pend));

   assign irq_req = pend & ~ctrl.mask;

   // R6: the mask bit blocks the request
   a_r6_mask_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      reg_rdata[BIT_MASK] |-> !irq_req);
endmodule

// File: tb/ext_irq_ctrl_bench.sv
module ext_irq_ctrl_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       irq_pin_n = 1'b1;
   logic       reg_wr = 1'b0;
   logic [7:0] reg_wdata = 8'h00;
   logic [7:0] reg_rdata;
   logic       vec_ack = 1'b0;
   logic       irq_req;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   always #4 clk = ~clk;

   ext_irq_ctrl u_ext_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .irq_pin_n(irq_pin_n), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .vec_ack(vec_ack),
      .irq_req(irq_req));

   // reference model built from the requirements
   logic m_s0, m_s1, m_prev, m_pend, m_acked, m_mask, m_mode;
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         m_s0 <= 1; m_s1 <= 1; m_prev <= 1;
         m_pend <= 0; m_acked <= 0; m_mask <= 0; m_mode <= 0;
      end else begin
         automatic logic f = m_prev & ~m_s1;
         automatic logic a = vec_ack | (reg_wr & reg_wdata[2]);
         m_s0 <= irq_pin_n; m_s1 <= m_s0; m_prev <= m_s1;
         if (f || (m_mode && !m_s1 && !m_pend)) begin
            m_pend <= 1; m_acked <= 0;
         end else if (m_pend) begin
            if (m_mode) begin
               if ((m_acked || a) && m_s1) begin m_pend <= 0; m_acked <= 0; end
               else if (a) m_acked <= 1;
            end else if (a) begin
               m_pend <= 0; m_acked <= 0;
            end
         end
         if (reg_wr) begin m_mask <= reg_wdata[1]; m_mode <= reg_wdata[0]; end
      end
   end

   function automatic logic [7:0] exp_rd();
      return {4'b0000, m_pend, 1'b0, m_mask, m_mode};
   endfunction

   task automatic check(string req, logic [8:0] act, logic [8:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual rd=%h req=%b expected rd=%h req=%b",
                  req, act[8:1], act[0], exp[8:1], exp[0]);
      end
   endtask

   task automatic check_model(string req);
      check(req, {reg_rdata, irq_req}, {exp_rd(), m_pend & ~m_mask});
   endtask

   task automatic check_flag(string req, logic exp);
      n_tests++;
      if (reg_rdata[3] !== exp) begin
         n_fail++;
         $display("FAIL %s: actual flag=%b expected flag=%b", req, reg_rdata[3], exp);
      end
   endtask

   task automatic step(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic wr(logic [7:0] d);
      reg_wr = 1; reg_wdata = d; step(1); reg_wr = 0; reg_wdata = 8'h00;
   endtask

   task automatic ack_pulse();
      vec_ack = 1; step(1); vec_ack = 0;
   endtask

   initial begin
      step(100000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd4242));
      // R1: reset with pin low
      irq_pin_n = 0;
      step(3);
      check("R1", {reg_rdata, irq_req}, 9'h000);
      rst_n = 1; irq_pin_n = 1;
      step(6);
      check_model("R1_post");
      wr(8'h04); step(1);
      check("R1", {reg_rdata, irq_req}, 9'h000);

      // R2: edge sets flag on third edge
      irq_pin_n = 0;
      step(2); check_flag("R2 early", 0);
      step(1); check_flag("R2", 1); check_model("R2");
      // R9: write with bit 2 clear keeps flag
      wr(8'h00); check_flag("R9", 1);
      // R3: vector ack clears, low pin does not re-set
      ack_pulse(); check_flag("R3", 0);
      step(5); check_flag("R3 held low", 0);
      // R3: software clear
      irq_pin_n = 1; step(4); irq_pin_n = 0; step(3);
      check_flag("R2 again", 1);
      wr(8'hF4); check_flag("R3 soft", 0);
      check("R7", {reg_rdata, irq_req}, 9'h000);

      // R6: mask blocks but latches
      wr(8'h02); irq_pin_n = 1; step(4); irq_pin_n = 0; step(3);
      check("R6", {reg_rdata, irq_req}, {8'h0A, 1'b0});
      wr(8'h00);
      check("R6 unmask", {reg_rdata, irq_req}, {8'h08, 1'b1});

      // R8: edge coincides with ack while pending
      irq_pin_n = 1; step(4); check_flag("R8 pre", 1);
      irq_pin_n = 0; step(2); ack_pulse();
      check_flag("R8", 1);
      ack_pulse(); check_flag("R3", 0);

      // R4: level mode with pin already low
      step(3); wr(8'h01); step(2);
      check("R4", {reg_rdata, irq_req}, {8'h09, 1'b1});
      // R5: ack first, then pin high
      ack_pulse(); step(3); check_flag("R5 ack low", 1);
      irq_pin_n = 1; step(2); check_flag("R5 sync", 1);
      step(1); check_flag("R5 clear", 0);
      // R5: pin high first, then ack
      irq_pin_n = 0; step(3); check_flag("R5 set", 1);
      irq_pin_n = 1; step(5); check_flag("R5 high no ack", 1);
      ack_pulse(); check_flag("R5 clear2", 0);
      check_model("R5");

      // constrained random
      for (int i = 0; i < 4000; i++) begin
         if ($urandom_range(7) == 0) irq_pin_n = ~irq_pin_n;
         vec_ack = ($urandom_range(15) == 0);
         reg_wr  = ($urandom_range(9) == 0);
         reg_wdata = reg_wr ? 8'($urandom) : 8'h00;
         step(1);
         check_model("R2-R9 random: R5");
      end
      vec_ack = 0; reg_wr = 0;
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule